// File: doc/BRIEF.md
# Tree Network Merge/Steer Node

This block is one node of a tree-shaped on-chip network that connects memory-controller endpoints to the I/O ports at the chip edge without a crossbar. Controllers never exchange traffic with each other, so every packet either climbs the tree toward an edge output or descends from an edge input toward one controller. The node therefore has two independent halves and no route computation.

The upward half merges two streams onto one output toward the edge: packets from the controller attached to this node, and packets already in the tree that arrive from the node below. A single round-robin arbiter picks between them one whole packet at a time. The downward half takes packets arriving from the node above and steers each one, using a single destination bit in its head flit, either to the attached controller or to the node further down.

Every input buffers flits per virtual channel (default 4 channels, 4 flits each, 128-bit payload, packets of up to 4 flits). Flow control is credit based rather than ready based: an input stream carries `valid` with channel, head and tail marks, and the sender may assert `valid` on a channel only while it holds a credit for it. Every sender starts with a full set of credits per channel, spends one per flit, and regains one for each single-cycle pulse on the matching bit of the node's credit output. Symmetrically, the node spends its own credits toward each output and regains them from the credit inputs; it never drives `valid` on a channel with no credit left.

Top module: `tree_node`

## Requirements
- R1: After reset all three outputs are idle (valid low) and no credit output pulses.
- R2: A flit presented on an idle input at clock edge k appears on its output after edge k+1, and the credit for its channel pulses on that input's credit output (bit number = channel) in the same cycle; a credit output never pulses more than one bit at once.
- R3: Each input holds up to 4 flits per channel; flits queued on one channel while the output is stalled are all delivered later in arrival order.
- R4: When both upward inputs have a packet waiting, grants alternate between them packet by packet; the controller input has the first turn after reset.
- R5: Once a head flit leaves on the upward output, every following flit until its tail comes from the same input and channel; head is set only on the first flit and tail only on the last.
- R6: The node starts with 4 credits per channel on each output, sends on a channel only while it holds a credit, and resumes one flit per returned credit.
- R7: A downward packet whose head flit has destination bit STEER_BIT set (default bit 0) goes entirely to the controller output; with the bit clear it goes entirely to the next-node output. Body and tail flits follow the head regardless of their own destination field.
- R8: The next-node output carries each flit's destination field unchanged.
- R9: A channel without credits does not block another channel on the same input that has credits.
- R10: The downward input returns exactly one credit per flit it forwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_valid | input | 1 | Flit from attached controller (upward) |
| loc_vc | input | VCW | Channel of controller flit |
| loc_head | input | 1 | First flit of packet |
| loc_tail | input | 1 | Last flit of packet |
| loc_data | input | DATA_W | Controller flit payload |
| loc_credit | output | NVC | Credit pulses back to controller |
| tre_valid | input | 1 | Flit from node below (upward) |
| tre_vc | input | VCW | Channel of in-tree flit |
| tre_head | input | 1 | First flit of packet |
| tre_tail | input | 1 | Last flit of packet |
| tre_data | input | DATA_W | In-tree flit payload |
| tre_credit | output | NVC | Credit pulses back to node below |
| up_valid | output | 1 | Merged flit toward edge |
| up_vc | output | VCW | Channel of merged flit |
| up_head | output | 1 | First flit of packet |
| up_tail | output | 1 | Last flit of packet |
| up_data | output | DATA_W | Merged flit payload |
| up_credit | input | NVC | Credit pulses from edge side |
| dn_valid | input | 1 | Flit from node above (downward) |
| dn_vc | input | VCW | Channel of downward flit |
| dn_head | input | 1 | First flit of packet |
| dn_tail | input | 1 | Last flit of packet |
| dn_dst | input | DST_W | Destination field |
| dn_data | input | DATA_W | Downward flit payload |
| dn_credit | output | NVC | Credit pulses back to node above |
| ctl_valid | output | 1 | Flit to attached controller |
| ctl_vc | output | VCW | Channel of controller-bound flit |
| ctl_head | output | 1 | First flit of packet |
| ctl_tail | output | 1 | Last flit of packet |
| ctl_data | output | DATA_W | Controller-bound payload |
| ctl_credit | input | NVC | Credit pulses from controller |
| nxt_valid | output | 1 | Flit to next node down |
| nxt_vc | output | VCW | Channel of forwarded flit |
| nxt_head | output | 1 | First flit of packet |
| nxt_tail | output | 1 | Last flit of packet |
| nxt_dst | output | DST_W | Destination field, unchanged |
| nxt_data | output | DATA_W | Forwarded payload |
| nxt_credit | input | NVC | Credit pulses from next node |

## Verification
A stale or wrong merge lock shows on the upward output as a head flit in mid-packet or a flit on a different channel before the tail, visible the very cycle the bad flit leaves; the bench sees it as out-of-order tags. A credit counter that drifts shows within the four flits of a stalled channel: one flit too many or too few leaves before the manual credit pulse. A wrong steering latch sends a body flit to the other downward output in the cycle after the head, and a buffer pointer fault reorders or duplicates tags two cycles after the flits enter.

// File: rtl/tree_pkg.sv
package tree_pkg;
  typedef enum logic {SRC_LOC = 1'b0, SRC_TREE = 1'b1} src_e;

  function automatic src_e other_src(input src_e s);
    return (s == SRC_LOC) ? SRC_TREE : SRC_LOC;
  endfunction
endpackage

// File: rtl/tree_vc_buf.sv
module tree_vc_buf #(
  parameter int W = 8,
  parameter int NVC = 4,
  parameter int DEPTH = 4,
  localparam int VCW = (NVC > 1) ? $clog2(NVC) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [VCW-1:0]          wr_vc,
  input  logic [W-1:0]            wr_flit,
  input  logic                    rd_en,
  input  logic [VCW-1:0]          rd_vc,
  output logic [NVC-1:0]          ne,
  output logic [NVC-1:0][W-1:0]   front,
  output logic [NVC-1:0]          credit_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  for (genvar v = 0; v < NVC; v++) begin : g_vc
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          wr_here, rd_here;

    assign wr_here  = wr_en && (wr_vc == VCW'(v));
    assign rd_here  = rd_en && (rd_vc == VCW'(v));
    assign ne[v]    = (cnt != '0);
    assign front[v] = mem[rp];

    always_ff @(posedge clk) begin
      if (wr_here) mem[wp] <= wr_flit;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (wr_here) wp <= PW'(wp + 1'b1);
        if (rd_here) rp <= PW'(rp + 1'b1);
        cnt <= cnt + CW'(wr_here) - CW'(rd_here);
      end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_here |-> (cnt < CW'(DEPTH))); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      rd_here |-> (cnt != '0)); // R3
  end

  always_ff @(posedge clk) begin
    if (!rst_n) credit_o <= '0;
    else        credit_o <= rd_en ? (NVC'(1) << rd_vc) : '0;
  end

  AST_CREDIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(credit_o)); // R2
endmodule

// File: rtl/tree_credit_bank.sv
module tree_credit_bank #(
  parameter int NVC = 4,
  parameter int DEPTH = 4,
  localparam int VCW = (NVC > 1) ? $clog2(NVC) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic [VCW-1:0] take_vc,
  input  logic [NVC-1:0] ret,
  output logic [NVC-1:0] avail
);
  localparam int CW = $clog2(DEPTH + 1);

  for (genvar v = 0; v < NVC; v++) begin : g_cnt
    logic [CW-1:0] cnt;
    logic          use_here;

    assign use_here = take && (take_vc == VCW'(v));
    assign avail[v] = (cnt != '0);

    always_ff @(posedge clk) begin
      if (!rst_n) cnt <= CW'(DEPTH);
      else        cnt <= cnt + CW'(ret[v]) - CW'(use_here);
    end

    AST_NO_SPEND_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      use_here |-> (cnt != '0)); // R6
    AST_NO_EXCESS_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      (ret[v] && !use_here) |-> (cnt < CW'(DEPTH))); // R6
  end
endmodule

// File: rtl/tree_merge_arb.sv
module tree_merge_arb
  import tree_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  input  logic       hold_rdy,
  input  logic       sel_tail,
  output src_e       gnt,
  output logic       fire,
  output logic       locked
);
  src_e rr, owner;
  logic want_rr, want_other;

  assign want_rr    = (rr == SRC_LOC) ? req[0] : req[1];
  assign want_other = (rr == SRC_LOC) ? req[1] : req[0];

  always_comb begin
    if (locked) begin
      gnt  = owner;
      fire = hold_rdy;
    end else begin
      gnt  = want_rr ? rr : other_src(rr);
      fire = want_rr || want_other;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr     <= SRC_LOC;
      owner  <= SRC_LOC;
      locked <= 1'b0;
    end else if (fire && !locked) begin
      rr <= other_src(gnt);
      if (!sel_tail) begin
        locked <= 1'b1;
        owner  <= gnt;
      end
    end else if (fire && locked && sel_tail) begin
      locked <= 1'b0;
    end
  end

  AST_LOCK_KEEPS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked) && rst_n) |-> $stable(gnt)); // R5
endmodule

// File: rtl/tree_node.sv
module tree_node
  import tree_pkg::*;
#(
  parameter int NVC = 4,
  parameter int DEPTH = 4,
  parameter int DATA_W = 128,
  parameter int DST_W = 4,
  parameter int STEER_BIT = 0,
  localparam int VCW = (NVC > 1) ? $clog2(NVC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loc_valid,
  input  logic [VCW-1:0]    loc_vc,
  input  logic              loc_head,
  input  logic              loc_tail,
  input  logic [DATA_W-1:0] loc_data,
  output logic [NVC-1:0]    loc_credit,
  input  logic              tre_valid,
  input  logic [VCW-1:0]    tre_vc,
  input  logic              tre_head,
  input  logic              tre_tail,
  input  logic [DATA_W-1:0] tre_data,
  output logic [NVC-1:0]    tre_credit,
  output logic              up_valid,
  output logic [VCW-1:0]    up_vc,
  output logic              up_head,
  output logic              up_tail,
  output logic [DATA_W-1:0] up_data,
  input  logic [NVC-1:0]    up_credit,
  input  logic              dn_valid,
  input  logic [VCW-1:0]    dn_vc,
  input  logic              dn_head,
  input  logic              dn_tail,
  input  logic [DST_W-1:0]  dn_dst,
  input  logic [DATA_W-1:0] dn_data,
  output logic [NVC-1:0]    dn_credit,
  output logic              ctl_valid,
  output logic [VCW-1:0]    ctl_vc,
  output logic              ctl_head,
  output logic              ctl_tail,
  output logic [DATA_W-1:0] ctl_data,
  input  logic [NVC-1:0]    ctl_credit,
  output logic              nxt_valid,
  output logic [VCW-1:0]    nxt_vc,
  output logic              nxt_head,
  output logic              nxt_tail,
  output logic [DST_W-1:0]  nxt_dst,
  output logic [DATA_W-1:0] nxt_data,
  input  logic [NVC-1:0]    nxt_credit
);
  localparam int UW = DATA_W + 2;          // {head, tail, data}
  localparam int DW = DATA_W + DST_W + 2;  // {head, tail, dst, data}
  localparam int STEER_POS = DATA_W + STEER_BIT;

  // ---------------- upward (merge) half ----------------
  logic [NVC-1:0]         ne_loc, ne_tre, up_av;
  logic [NVC-1:0][UW-1:0] fr_loc, fr_tre;
  logic                   ok_loc, ok_tre, hold_rdy, m_fire, m_locked;
  logic [VCW-1:0]         pk_loc, pk_tre, m_vc, lock_vc;
  logic [UW-1:0]          m_flit;
  src_e                   m_gnt;

  tree_vc_buf #(.W(UW), .NVC(NVC), .DEPTH(DEPTH)) u_buf_loc (
    .clk, .rst_n, .wr_en(loc_valid), .wr_vc(loc_vc),
    .wr_flit({loc_head, loc_tail, loc_data}),
    .rd_en(m_fire && m_gnt == SRC_LOC), .rd_vc(m_vc),
    .ne(ne_loc), .front(fr_loc), .credit_o(loc_credit));

  tree_vc_buf #(.W(UW), .NVC(NVC), .DEPTH(DEPTH)) u_buf_tre (
    .clk, .rst_n, .wr_en(tre_valid), .wr_vc(tre_vc),
    .wr_flit({tre_head, tre_tail, tre_data}),
    .rd_en(m_fire && m_gnt == SRC_TREE), .rd_vc(m_vc),
    .ne(ne_tre), .front(fr_tre), .credit_o(tre_credit));

  tree_credit_bank #(.NVC(NVC), .DEPTH(DEPTH)) u_cr_up (
    .clk, .rst_n, .take(m_fire), .take_vc(m_vc), .ret(up_credit), .avail(up_av));

  always_comb begin
    ok_loc = 1'b0; pk_loc = '0;
    ok_tre = 1'b0; pk_tre = '0;
    for (int v = NVC - 1; v >= 0; v--) begin
      if (ne_loc[v] && up_av[v]) begin ok_loc = 1'b1; pk_loc = VCW'(v); end
      if (ne_tre[v] && up_av[v]) begin ok_tre = 1'b1; pk_tre = VCW'(v); end
    end
  end

  assign hold_rdy = up_av[lock_vc] &&
                    ((m_gnt == SRC_LOC) ? ne_loc[lock_vc] : ne_tre[lock_vc]);
  assign m_vc   = m_locked ? lock_vc : ((m_gnt == SRC_LOC) ? pk_loc : pk_tre);
  assign m_flit = (m_gnt == SRC_LOC) ? fr_loc[m_vc] : fr_tre[m_vc];

  tree_merge_arb u_arb (
    .clk, .rst_n, .req({ok_tre, ok_loc}), .hold_rdy, .sel_tail(m_flit[UW-2]),
    .gnt(m_gnt), .fire(m_fire), .locked(m_locked));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_vc  <= '0;
      up_valid <= 1'b0;
      up_vc    <= '0;
      up_head  <= 1'b0;
      up_tail  <= 1'b0;
      up_data  <= '0;
    end else begin
      if (m_fire && !m_locked) lock_vc <= m_vc;
      up_valid <= m_fire;
      if (m_fire) begin
        up_vc   <= m_vc;
        up_head <= m_flit[UW-1];
        up_tail <= m_flit[UW-2];
        up_data <= m_flit[DATA_W-1:0];
      end
    end
  end

  // ---------------- downward (steer) half ----------------
  logic [NVC-1:0]         ne_dn, ctl_av, nxt_av;
  logic [NVC-1:0][DW-1:0] fr_dn;
  logic                   d_lock, d_local, d_go, d_sel_local, pk_ok, pk_local;
  logic [VCW-1:0]         d_vc, d_sel_vc, pk_vc;
  logic [DW-1:0]          d_flit;

  tree_vc_buf #(.W(DW), .NVC(NVC), .DEPTH(DEPTH)) u_buf_dn (
    .clk, .rst_n, .wr_en(dn_valid), .wr_vc(dn_vc),
    .wr_flit({dn_head, dn_tail, dn_dst, dn_data}),
    .rd_en(d_go), .rd_vc(d_sel_vc),
    .ne(ne_dn), .front(fr_dn), .credit_o(dn_credit));

  tree_credit_bank #(.NVC(NVC), .DEPTH(DEPTH)) u_cr_ctl (
    .clk, .rst_n, .take(d_go && d_sel_local), .take_vc(d_sel_vc),
    .ret(ctl_credit), .avail(ctl_av));

  tree_credit_bank #(.NVC(NVC), .DEPTH(DEPTH)) u_cr_nxt (
    .clk, .rst_n, .take(d_go && !d_sel_local), .take_vc(d_sel_vc),
    .ret(nxt_credit), .avail(nxt_av));

  always_comb begin
    pk_ok = 1'b0; pk_vc = '0; pk_local = 1'b0;
    for (int v = NVC - 1; v >= 0; v--) begin
      if (ne_dn[v] && (fr_dn[v][STEER_POS] ? ctl_av[v] : nxt_av[v])) begin
        pk_ok    = 1'b1;
        pk_vc    = VCW'(v);
        pk_local = fr_dn[v][STEER_POS];
      end
    end
  end

  assign d_sel_vc    = d_lock ? d_vc : pk_vc;
  assign d_sel_local = d_lock ? d_local : pk_local;
  assign d_go        = d_lock ? (ne_dn[d_vc] && (d_local ? ctl_av[d_vc] : nxt_av[d_vc]))
                              : pk_ok;
  assign d_flit      = fr_dn[d_sel_vc];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_lock    <= 1'b0;
      d_vc      <= '0;
      d_local   <= 1'b0;
      ctl_valid <= 1'b0;
      nxt_valid <= 1'b0;
      ctl_vc    <= '0; ctl_head <= 1'b0; ctl_tail <= 1'b0; ctl_data <= '0;
      nxt_vc    <= '0; nxt_head <= 1'b0; nxt_tail <= 1'b0; nxt_data <= '0;
      nxt_dst   <= '0;
    end else begin
      if (d_go && !d_lock && !d_flit[DW-2]) begin
        d_lock  <= 1'b1;
        d_vc    <= d_sel_vc;
        d_local <= d_sel_local;
      end else if (d_go && d_lock && d_flit[DW-2]) begin
        d_lock <= 1'b0;
      end
      ctl_valid <= d_go && d_sel_local;
      nxt_valid <= d_go && !d_sel_local;
      if (d_go && d_sel_local) begin
        ctl_vc   <= d_sel_vc;
        ctl_head <= d_flit[DW-1];
        ctl_tail <= d_flit[DW-2];
        ctl_data <= d_flit[DATA_W-1:0];
      end
      if (d_go && !d_sel_local) begin
        nxt_vc   <= d_sel_vc;
        nxt_head <= d_flit[DW-1];
        nxt_tail <= d_flit[DW-2];
        nxt_dst  <= d_flit[DATA_W +: DST_W];
        nxt_data <= d_flit[DATA_W-1:0];
      end
    end
  end

  // ---------------- output framing observers ----------------
  logic           up_in_pkt, ctl_in_pkt, nxt_in_pkt;
  logic [VCW-1:0] up_pkt_vc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_in_pkt  <= 1'b0;
      ctl_in_pkt <= 1'b0;
      nxt_in_pkt <= 1'b0;
      up_pkt_vc  <= '0;
    end else begin
      if (up_valid)  begin up_in_pkt <= !up_tail; up_pkt_vc <= up_vc; end
      if (ctl_valid) ctl_in_pkt <= !ctl_tail;
      if (nxt_valid) nxt_in_pkt <= !nxt_tail;
    end
  end

  AST_UP_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |-> (up_head == !up_in_pkt)); // R5
  AST_UP_SAME_VC: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_in_pkt) |-> (up_vc == up_pkt_vc)); // R5
  AST_CTL_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid |-> (ctl_head == !ctl_in_pkt)); // R7
  AST_NXT_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_valid |-> (nxt_head == !nxt_in_pkt)); // R7
endmodule

// File: tb/test_tree_node.sv
module test_tree_node;
  localparam int NVC = 4;
  localparam int VCW = 2;
  localparam int DATA_W = 128;
  localparam int DST_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              loc_valid = 0, loc_head = 0, loc_tail = 0;
  logic [VCW-1:0]    loc_vc = '0;
  logic [DATA_W-1:0] loc_data = '0;
  logic [NVC-1:0]    loc_credit;
  logic              tre_valid = 0, tre_head = 0, tre_tail = 0;
  logic [VCW-1:0]    tre_vc = '0;
  logic [DATA_W-1:0] tre_data = '0;
  logic [NVC-1:0]    tre_credit;
  logic              up_valid, up_head, up_tail;
  logic [VCW-1:0]    up_vc;
  logic [DATA_W-1:0] up_data;
  logic [NVC-1:0]    up_credit = '0;
  logic              dn_valid = 0, dn_head = 0, dn_tail = 0;
  logic [VCW-1:0]    dn_vc = '0;
  logic [DST_W-1:0]  dn_dst = '0;
  logic [DATA_W-1:0] dn_data = '0;
  logic [NVC-1:0]    dn_credit;
  logic              ctl_valid, ctl_head, ctl_tail;
  logic [VCW-1:0]    ctl_vc;
  logic [DATA_W-1:0] ctl_data;
  logic [NVC-1:0]    ctl_credit = '0;
  logic              nxt_valid, nxt_head, nxt_tail;
  logic [VCW-1:0]    nxt_vc;
  logic [DST_W-1:0]  nxt_dst;
  logic [DATA_W-1:0] nxt_data;
  logic [NVC-1:0]    nxt_credit = '0;

  tree_node i_tree_node (.*);

  int  checks = 0, fails = 0, cyc = 0, dn_ret = 0;
  bit  auto_up = 1'b1;
  logic [19:0] up_q[$];   // {head, tail, vc, tag}
  logic [19:0] ctl_q[$];
  logic [23:0] nxt_q[$];  // {head, tail, vc, dst, tag}

  initial forever begin @(posedge clk); cyc++; end

  initial forever begin
    @(negedge clk);
    if (up_valid)  up_q.push_back({up_head, up_tail, up_vc, up_data[15:0]});
    if (ctl_valid) ctl_q.push_back({ctl_head, ctl_tail, ctl_vc, ctl_data[15:0]});
    if (nxt_valid) nxt_q.push_back({nxt_head, nxt_tail, nxt_vc, nxt_dst, nxt_data[15:0]});
    dn_ret += $countones(dn_credit);
    if (auto_up) up_credit = up_valid ? (NVC'(1) << up_vc) : '0;
    ctl_credit = ctl_valid ? (NVC'(1) << ctl_vc) : '0;
    nxt_credit = nxt_valid ? (NVC'(1) << nxt_vc) : '0;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drv_loc(input int vc, input logic h, input logic t, input logic [15:0] tag);
    loc_valid = 1; loc_vc = VCW'(vc); loc_head = h; loc_tail = t; loc_data = DATA_W'(tag);
    @(negedge clk);
    loc_valid = 0;
  endtask

  task automatic drv_both(input logic h, input logic t, input logic [15:0] a, input logic [15:0] b);
    loc_valid = 1; loc_vc = '0; loc_head = h; loc_tail = t; loc_data = DATA_W'(a);
    tre_valid = 1; tre_vc = '0; tre_head = h; tre_tail = t; tre_data = DATA_W'(b);
    @(negedge clk);
    loc_valid = 0; tre_valid = 0;
  endtask

  task automatic drv_dn(input int vc, input logic h, input logic t,
                        input logic [DST_W-1:0] dst, input logic [15:0] tag);
    dn_valid = 1; dn_vc = VCW'(vc); dn_head = h; dn_tail = t; dn_dst = dst;
    dn_data = DATA_W'(tag);
    @(negedge clk);
    dn_valid = 0;
  endtask

  task automatic t_reset;
    check("R1 up idle", up_valid, 0);
    check("R1 down idle", {ctl_valid, nxt_valid}, 0);
    check("R1 no credit pulses", {loc_credit, tre_credit, dn_credit}, 0);
  endtask

  task automatic t_latency;
    up_q.delete();
    tre_valid = 1; tre_vc = 2; tre_head = 1; tre_tail = 1; tre_data = DATA_W'(16'h0021);
    @(negedge clk);
    tre_valid = 0;
    check("R2 not yet out", up_valid, 0);
    check("R2 no early credit", tre_credit, 0);
    @(negedge clk);
    check("R2 out after two edges", up_valid, 1);
    check("R2 channel and tag", {up_vc, up_data[15:0]}, {2'd2, 16'h0021});
    check("R2 credit pulse", tre_credit, 4'b0100);
    idle(4);
  endtask

  task automatic t_round_robin;
    logic [15:0] exp_tag[8] = '{16'h11, 16'h12, 16'h21, 16'h22, 16'h13, 16'h14, 16'h23, 16'h24};
    up_q.delete();
    drv_both(1, 0, 16'h11, 16'h21);
    drv_both(0, 1, 16'h12, 16'h22);
    drv_both(1, 0, 16'h13, 16'h23);
    drv_both(0, 1, 16'h14, 16'h24);
    idle(15);
    check("R4 flit count", up_q.size(), 8);
    for (int i = 0; i < 8; i++) begin
      if (i < up_q.size()) begin
        check("R4 packet order", up_q[i][15:0], exp_tag[i]);
        check("R5 head/tail marks", up_q[i][19:18], (i % 2 == 0) ? 2'b10 : 2'b01);
      end
    end
  endtask

  task automatic t_credit;
    up_q.delete();
    auto_up = 0; up_credit = '0;
    for (int i = 0; i < 4; i++) drv_loc(0, 1, 1, 16'h31 + 16'(i));
    idle(6);
    drv_loc(0, 1, 1, 16'h35);
    drv_loc(0, 1, 1, 16'h36);
    idle(6);
    check("R6 stops at four credits", up_q.size(), 4);
    drv_loc(1, 1, 1, 16'h41);
    idle(4);
    check("R9 other channel passes", up_q.size(), 5);
    if (up_q.size() == 5) check("R9 tag and channel", {up_q[4][17:16], up_q[4][15:0]}, {2'd1, 16'h41});
    up_credit = 4'b0001; @(negedge clk); up_credit = '0;
    idle(4);
    check("R6 one flit per credit", up_q.size(), 6);
    up_credit = 4'b0011; @(negedge clk);
    up_credit = 4'b0001; repeat (4) @(negedge clk);
    up_credit = '0;
    idle(4);
    check("R3 all queued flits delivered", up_q.size(), 7);
    if (up_q.size() == 7) begin
      check("R3 order kept", {up_q[5][15:0], up_q[6][15:0]}, {16'h35, 16'h36});
      check("R6 first four in order", {up_q[0][15:0], up_q[3][15:0]}, {16'h31, 16'h34});
    end
    auto_up = 1;
    idle(2);
  endtask

  task automatic t_steer;
    ctl_q.delete(); nxt_q.delete(); dn_ret = 0;
    drv_dn(1, 1, 0, 4'b0101, 16'h51);
    drv_dn(1, 0, 0, 4'b0000, 16'h52);
    drv_dn(1, 0, 1, 4'b0000, 16'h53);
    drv_dn(3, 1, 0, 4'b1010, 16'h61);
    drv_dn(3, 0, 1, 4'b1111, 16'h62);
    drv_dn(0, 1, 1, 4'b0001, 16'h71);
    idle(6);
    check("R7 controller flit count", ctl_q.size(), 4);
    check("R7 next-node flit count", nxt_q.size(), 2);
    if (ctl_q.size() == 4) begin
      check("R7 body follows head", {ctl_q[1][15:0], ctl_q[2][15:0]}, {16'h52, 16'h53});
      check("R7 marks", {ctl_q[0][19:18], ctl_q[2][19:18], ctl_q[3][19:18]}, 6'b10_01_11);
      check("R7 single-flit packet", {ctl_q[3][17:16], ctl_q[3][15:0]}, {2'd0, 16'h71});
    end
    if (nxt_q.size() == 2) begin
      check("R8 head dst unchanged", {nxt_q[0][19:16], nxt_q[0][15:0]}, {4'b1010, 16'h61});
      check("R8 tail dst unchanged", {nxt_q[1][19:16], nxt_q[1][15:0]}, {4'b1111, 16'h62});
      check("R7 channel kept", nxt_q[1][21:20], 2'd3);
    end
    check("R10 one credit per flit", dn_ret, 6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_round_robin();
    t_credit();
    t_steer();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule